// File: doc/BRIEF.md
# Timer with Compare-Match and Capture Flags

A 16-bit timer/counter that steps once for every clock cycle where its prescaler tick enable is high. It has three compare channels (A, B and C) and one input-capture channel. Five sticky status flags record its events: counter overflow, a match on each compare channel, and a capture. A small write-only register bus loads the compare values, the counter and the interrupt mask, and it also clears flags by writing ones to the flag register.

The counter runs in one of two modes. In free-running mode it counts up and wraps from all-ones to zero. In clear-on-match mode it returns to zero on the tick after it equals compare A. A flag can be cleared by a per-flag acknowledge pulse from the interrupt controller or by software. When a hardware set and a clear land in the same cycle, the set wins. Each flag is ANDed with its mask bit to drive an interrupt request line. Forced-compare strobes produce a compare event for downstream waveform logic, but they never set a match flag.

Top module: `timer_cc`

## Requirements
- R1: When `tick_en` is high, `count` increases by one, and it wraps from 0xFFFF to 0. When `tick_en` is low and there is no counter write, `count` holds its value.
- R2: When `mode_ctc` is 1, a tick at which `count` equals compare A makes `count` 0 after that edge.
- R3: Flag bits 1, 2 and 3 belong to compares A, B and C. Such a bit sets on the first tick after the tick at which `count` equals that channel's compare value. It is not set at the matching tick itself.
- R4: A `force_cmp[i]` strobe drives `cmp_evt[i]` high in the same cycle and leaves the flags unchanged.
- R5: Flag bit 0 (overflow) sets on the tick at which `count` goes from 0xFFFF to 0. This holds in both modes.
- R6: A `cap_strobe` copies `count` into `cap_value` at the next clock edge. Flag bit 4 (capture) sets on the next tick after the strobe.
- R7: A high `ack[i]` clears flag bit i at the next clock edge.
- R8: Writing address 3 clears every flag bit whose data bit is 1. Flag bits whose data bit is 0 keep their value.
- R9: A set and a clear of the same flag in the same cycle leave that flag set.
- R10: `irq[i]` is high exactly when flag bit i is set and bit i of the mask register (address 4) is 1.
- R11: Address map:
  - Addresses 0, 1 and 2 hold compares A, B and C.
  - Address 3 is the flag clear.
  - Address 4 is the mask.
  - Address 5 loads `count`. This load takes priority over a tick and discards any pending compare match.
- R12: During and after reset, `count`, `flags`, `irq` and `cap_value` are 0. The compare values reset to 0xFFFF and the mask resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Prescaler tick; the timer advances only when high |
| mode_ctc | input | 1 | 1 = clear on compare A, 0 = free running |
| cap_strobe | input | 1 | Capture request |
| force_cmp | input | 3 | Forced-compare strobes for C, B, A (bit 2..0) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| ack | input | 5 | Per-flag vector acknowledge pulses |
| flags | output | 5 | Flag vector: 0 overflow, 1..3 compare A..C, 4 capture |
| irq | output | 5 | Masked interrupt requests |
| count | output | 16 | Counter value |
| cap_value | output | 16 | Last captured counter value |
| cmp_evt | output | 3 | Compare events (match flag set or forced), C..A |

## Verification
A compare flag is due two ticks after the counter first shows the matching value. The first tick registers the match and the second sets the flag. The overflow flag, a counter load and the clear-on-match return to zero all show one clock edge after their tick or write. A capture shows in `cap_value` one edge after the strobe, and its flag shows at the next tick. Inputs change one time unit after a rising edge and every result is read just before the next edge, so each expected value is compared in the single cycle in which it first becomes valid.

// File: rtl/timer_cc.sv
module timer_cc #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          mode_ctc,
  input  logic          cap_strobe,
  input  logic [2:0]    force_cmp,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [4:0]    ack,
  output logic [4:0]    flags,
  output logic [4:0]    irq,
  output logic [CW-1:0] count,
  output logic [CW-1:0] cap_value,
  output logic [2:0]    cmp_evt
);
  localparam logic [CW-1:0] TOP = '1;

  logic [CW-1:0] cmp_a, cmp_b, cmp_c;
  logic [4:0]    mask;
  logic [2:0]    match_q;
  logic          cap_pend;
  logic [4:0]    set, clr;

  wire wr_cnt = wr_en && (wr_addr == 3'd5);
  wire wr_flg = wr_en && (wr_addr == 3'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_a <= TOP;
      cmp_b <= TOP;
      cmp_c <= TOP;
      mask  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: cmp_a <= wr_data;
        3'd1: cmp_b <= wr_data;
        3'd2: cmp_c <= wr_data;
        3'd4: mask  <= wr_data[4:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      count <= '0;
    else if (wr_cnt)
      count <= wr_data;
    else if (tick_en)
      count <= (mode_ctc && count == cmp_a) ? '0 : count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || wr_cnt)
      match_q <= '0;
    else if (tick_en)
      match_q <= {count == cmp_c, count == cmp_b, count == cmp_a};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_value <= '0;
      cap_pend  <= 1'b0;
    end else if (cap_strobe) begin
      cap_value <= count;
      cap_pend  <= 1'b1;
    end else if (tick_en) begin
      cap_pend  <= 1'b0;
    end
  end

  assign set = {tick_en && cap_pend,
                {3{tick_en}} & match_q,
                tick_en && !wr_cnt && count == TOP};
  assign clr = ack | ({5{wr_flg}} & wr_data[4:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= set | (flags & ~clr);
  end

  assign irq     = flags & mask;
  assign cmp_evt = ({3{tick_en}} & match_q) | force_cmp;
endmodule

module timer_cc_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic          mode_ctc,
  input logic          wr_en,
  input logic [2:0]    wr_addr,
  input logic [4:0]    ack,
  input logic [4:0]    flags,
  input logic [4:0]    irq,
  input logic [CW-1:0] count,
  input logic [CW-1:0] cmp_a
);
  wire ld = wr_en && wr_addr == 3'd5;
  wire fw = wr_en && wr_addr == 3'd3;

  a_r1_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !ld) |=> $stable(count));

  a_r2_ctc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ctc && tick_en && !ld && count == cmp_a) |=> (count == '0));

  a_r5_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !ld && count == '1) |=> flags[0]);

  a_r7_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[0] && !(tick_en && count == '1)) |=> !flags[0]);

  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~flags) == 5'd0));

  a_r3_no_idle_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && ack == 5'd0 && !fw) |=> $stable(flags));
endmodule

bind timer_cc timer_cc_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_ctc(mode_ctc),
  .wr_en(wr_en), .wr_addr(wr_addr), .ack(ack), .flags(flags),
  .irq(irq), .count(count), .cmp_a(cmp_a)
);

// File: tb/timer_cc_bench.sv
module timer_cc_bench;
  logic        clk = 0, rst_n = 0, tick_en = 0, mode_ctc = 0, cap_strobe = 0;
  logic [2:0]  force_cmp = 0;
  logic        wr_en = 0;
  logic [2:0]  wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [4:0]  ack = 0;
  logic [4:0]  flags, irq;
  logic [15:0] count, cap_value;
  logic [2:0]  cmp_evt;
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  timer_cc u_timer_cc (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 0;
  endtask

  task automatic tick(int n);
    tick_en = 1;
    repeat (n) cyc();
    tick_en = 0;
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) cyc();
    chk("R12 count", count, 0);
    chk("R12 flags", flags, 0);
    chk("R12 irq", irq, 0);
    chk("R12 cap", cap_value, 0);
    rst_n = 1;
    cyc();
  endtask

  task automatic t_count();
    wr(5, 16'd10);
    chk("R11 load", count, 10);
    tick(5);
    chk("R1 count", count, 15);
    repeat (3) cyc();
    chk("R1 hold", count, 15);
  endtask

  task automatic t_match();
    wr(0, 16'd20); wr(1, 16'd40); wr(5, 16'd18); wr(3, 16'h1F);
    tick(3);
    chk("R3 count", count, 21);
    chk("R3 not yet", flags[1], 0);
    tick(1);
    chk("R3 flag A", flags, 5'b00010);
    wr(5, 16'd39); wr(3, 16'h1F);
    tick(2);
    chk("R3 B early", flags[2], 0);
    tick(1);
    chk("R3 flag B", flags, 5'b00100);
  endtask

  task automatic t_force();
    wr(3, 16'h1F);
    force_cmp = 3'b101; #1;
    chk("R4 evt", cmp_evt, 3'b101);
    cyc();
    force_cmp = 0;
    cyc();
    chk("R4 no flag", flags, 0);
  endtask

  task automatic t_ovf();
    wr(5, 16'hFFFE); wr(3, 16'h1F);
    tick(1);
    chk("R5 early", flags[0], 0);
    tick(1);
    chk("R1 wrap", count, 0);
    chk("R5 ovf", flags[0], 1);
  endtask

  task automatic t_ctc();
    wr(0, 16'd5); mode_ctc = 1;
    wr(5, 16'd3); wr(3, 16'h1F);
    tick(2);
    chk("R2 at cmp", count, 5);
    tick(1);
    chk("R2 cleared", count, 0);
    tick(1);
    chk("R3 ctc flag", flags, 5'b00010);
    mode_ctc = 0;
  endtask

  task automatic t_capture();
    wr(5, 16'd40); wr(3, 16'h1F);
    cap_strobe = 1; cyc(); cap_strobe = 0;
    chk("R6 value", cap_value, 40);
    chk("R6 flag wait", flags[4], 0);
    tick(1);
    chk("R6 flag", flags[4], 1);
    ack = 5'b10000; cyc(); ack = 0;
    chk("R7 ack", flags[4], 0);
  endtask

  task automatic t_w1c();
    wr(0, 16'd100); wr(1, 16'd100); wr(2, 16'd100);
    wr(5, 16'd99); wr(3, 16'h1F);
    tick(3);
    chk("R3 three", flags, 5'b01110);
    wr(3, 16'b01010);
    chk("R8 w1c", flags, 5'b00100);
  endtask

  task automatic t_setwins();
    wr(5, 16'hFFFF); wr(3, 16'h1F);
    ack = 5'b00001; tick_en = 1; cyc(); tick_en = 0; ack = 0;
    chk("R9 set wins", flags[0], 1);
  endtask

  task automatic t_mask();
    wr(4, 16'b00001);
    chk("R10 irq", irq, 5'b00001);
    wr(4, 16'b00000);
    chk("R10 masked", irq, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_count();
    t_match();
    t_force();
    t_ovf();
    t_ctc();
    t_capture();
    t_w1c();
    t_setwins();
    t_mask();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule